// File: doc/BRIEF.md
# Circular Interrupt Queue Writer

This block gathers interrupt-status words from on-chip producers and deposits them, one 32-bit word at a time, into a circular queue held in host memory. Three producers feed it: an action-acknowledge source, a frame-indication source that carries a channel number, and a general source that supplies a complete 32-bit word. When several request in the same cycle, a fixed priority picks one. Each chosen word gets its top bit set as a valid marker, is issued as a single-beat write request, and is held until memory acknowledges it.

Software sets the queue's base byte address and a length code. Loading a new base moves the write pointer to that base. The queue holds a number of words equal to the length code plus one, times sixteen. After the last word the pointer returns to the base. While the base is zero no queue exists: requests are still consumed, but nothing is written. A one-cycle interrupt pulse follows each write that memory has acknowledged.

Top module: `irq_ring_writer`

## Requirements
- R1: After reset, `mem_req`, `irq`, `ack_done`, `fi_done` and `gen_done` are all 0, and the queue base is zero.
- R2: A cycle with `base_we` high stores `base_in` as the queue base and moves the write pointer to it. The next write goes to `base_in`.
- R3: The queue holds (`len_code` + 1) * 16 words. Consecutive writes go to ascending addresses 4 bytes apart. The write that follows the one at base + 4*(words-1) goes to the base again.
- R4: Bit 31 of every word written is 1, whatever the source supplied. Bits 30..0 of a general post are written unchanged.
- R5: An acknowledge entry is written as 0x80008000. A frame-indication entry is 0x80001000 OR'd with the channel number in bits 4..0.
- R6: When requests arrive together, acknowledge is served first, then frame indication, then the general post.
- R7: While the base is zero, a request is consumed (its done pulses) and `mem_req` stays low.
- R8: Once `mem_req` rises, it stays high with `mem_addr` and `mem_data` stable until a cycle with `mem_ack` high. The pointer advances only on that cycle.
- R9: `irq` is high for exactly the one cycle that follows each cycle where `mem_req` and `mem_ack` are both high.
- R10: Each consumed request gives a single one-cycle pulse on its own done output. At most one done output is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_we | input | 1 | Load queue base and reset pointer |
| base_in | input | 32 | Queue base byte address |
| len_code | input | 8 | Queue length code; the queue holds (code+1)*16 words |
| ack_req | input | 1 | Action-acknowledge post request |
| ack_done | output | 1 | Acknowledge request consumed |
| fi_req | input | 1 | Frame-indication post request |
| fi_chan | input | 5 | Channel number for frame indication |
| fi_done | output | 1 | Frame-indication request consumed |
| gen_req | input | 1 | General post request |
| gen_word | input | 32 | General post value |
| gen_done | output | 1 | General request consumed |
| mem_req | output | 1 | Memory write request |
| mem_addr | output | 32 | Memory write byte address |
| mem_data | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory write accepted |
| irq | output | 1 | One-cycle pulse after each completed write |

## Verification
On every cycle, the assertions check the following: the write request and its address and data stay stable while memory has not acknowledged; every written word carries the valid bit; a write never starts with a zero base; the interrupt follows each acknowledged write and lasts one cycle; and the done pulses never overlap. Some behaviours are shown only by the bench's scenarios. These are the exact entry encodings, the address sequence with its wrap point for two different length codes, the move of the pointer on a base reload, the priority order among simultaneous requests, and the consumption of requests without a write while the base is zero.

// File: rtl/irq_ring_writer.sv
module irq_ring_writer #(
  parameter int CHAN_W     = 5,
  parameter int UNIT_WORDS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_we,
  input  logic [31:0]       base_in,
  input  logic [7:0]        len_code,
  input  logic              ack_req,
  output logic              ack_done,
  input  logic              fi_req,
  input  logic [CHAN_W-1:0] fi_chan,
  output logic              fi_done,
  input  logic              gen_req,
  input  logic [31:0]       gen_word,
  output logic              gen_done,
  output logic              mem_req,
  output logic [31:0]       mem_addr,
  output logic [31:0]       mem_data,
  input  logic              mem_ack,
  output logic              irq
);

  localparam logic [31:0] VALID_BIT = 32'h8000_0000;
  localparam logic [31:0] ACK_CODE  = 32'h0000_8000;
  localparam logic [31:0] FI_CODE   = 32'h0000_1000;
  localparam logic [31:0] UNIT_B    = 32'(UNIT_WORDS * 4);

  logic [31:0] base_q, ptr_q;

  wire [31:0] ring_bytes = ({24'd0, len_code} + 32'd1) * UNIT_B;
  wire [31:0] ptr_inc    = ptr_q + 32'd4;
  wire [31:0] ptr_nxt    = (ptr_inc >= base_q + ring_bytes) ? base_q : ptr_inc;
  wire        idle       = !mem_req;
  wire        any_req    = ack_req || fi_req || gen_req;
  wire        write_done = mem_req && mem_ack;
  wire [31:0] sel_word   = ack_req ? ACK_CODE :
                           fi_req  ? (FI_CODE | 32'(fi_chan)) : gen_word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q   <= '0;
      ptr_q    <= '0;
      mem_req  <= 1'b0;
      mem_addr <= '0;
      mem_data <= '0;
      ack_done <= 1'b0;
      fi_done  <= 1'b0;
      gen_done <= 1'b0;
      irq      <= 1'b0;
    end else begin
      ack_done <= idle && ack_req;
      fi_done  <= idle && !ack_req && fi_req;
      gen_done <= idle && !ack_req && !fi_req && gen_req;
      irq      <= write_done;
      if (idle && any_req && base_q != '0) begin
        mem_req  <= 1'b1;
        mem_addr <= ptr_q;
        mem_data <= sel_word | VALID_BIT;
      end else if (write_done) begin
        mem_req <= 1'b0;
      end
      if (base_we) begin
        base_q <= base_in;
        ptr_q  <= base_in;
      end else if (write_done) begin
        ptr_q <= ptr_nxt;
      end
    end
  end

  // R8
  hold_until_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_data));

  // R4
  valid_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_data[31]);

  // R7
  no_write_zero_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> $past(base_q) != '0);

  // R9
  irq_follows_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack |=> irq);

  // R9
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R10
  done_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ack_done, fi_done, gen_done}));

endmodule

// File: tb/irq_ring_writer_bench.sv
module irq_ring_writer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        base_we = 1'b0;
  logic [31:0] base_in = '0;
  logic [7:0]  len_code = '0;
  logic        ack_req = 1'b0, fi_req = 1'b0, gen_req = 1'b0;
  logic [4:0]  fi_chan = '0;
  logic [31:0] gen_word = '0;
  logic        ack_done, fi_done, gen_done;
  logic        mem_req, mem_ack = 1'b0, irq;
  logic [31:0] mem_addr, mem_data;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  irq_ring_writer u_irq_ring_writer (
    .clk, .rst_n, .base_we, .base_in, .len_code,
    .ack_req, .ack_done, .fi_req, .fi_chan, .fi_done,
    .gen_req, .gen_word, .gen_done,
    .mem_req, .mem_addr, .mem_data, .mem_ack, .irq);

  // {src(2): 0 ack,1 fi,2 gen ; payload(32) ; expected word(32)}
  localparam logic [65:0] TBL [8] = '{
    {2'd0, 32'h0000_0000, 32'h8000_8000},
    {2'd1, 32'h0000_0003, 32'h8000_1003},
    {2'd2, 32'h0000_0055, 32'h8000_0055},
    {2'd2, 32'h8000_1234, 32'h8000_1234},
    {2'd1, 32'h0000_001F, 32'h8000_101F},
    {2'd2, 32'h7FFF_FFFF, 32'hFFFF_FFFF},
    {2'd0, 32'h0000_0000, 32'h8000_8000},
    {2'd1, 32'h0000_0000, 32'h8000_1000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic post(input int src, input logic [31:0] payload);
    @(negedge clk);
    case (src)
      0: ack_req = 1'b1;
      1: begin fi_req = 1'b1; fi_chan = payload[4:0]; end
      default: begin gen_req = 1'b1; gen_word = payload; end
    endcase
    @(negedge clk);
    chk("R10 done pulse", {29'd0, ack_done, fi_done, gen_done},
        (src == 0) ? 32'd4 : (src == 1) ? 32'd2 : 32'd1);
    ack_req = 1'b0; fi_req = 1'b0; gen_req = 1'b0;
  endtask

  task automatic serve(input int delay, output logic [31:0] a, output logic [31:0] d);
    while (!mem_req) @(negedge clk);
    a = mem_addr; d = mem_data;
    for (int k = 0; k < delay; k++) begin
      @(negedge clk);
      chk("R8 held", {mem_req, mem_addr[30:0] ^ a[30:0]}, {1'b1, 31'd0});
      chk("R8 data stable", mem_data, d);
    end
    mem_ack = 1'b1;
    @(negedge clk);
    mem_ack = 1'b0;
    chk("R9 irq after ack", {31'd0, irq}, 32'd1);
  endtask

  task automatic set_base(input logic [31:0] b);
    @(negedge clk);
    base_we = 1'b1; base_in = b;
    @(negedge clk);
    base_we = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] a, d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 reset outputs", {27'd0, mem_req, irq, ack_done, fi_done, gen_done}, 32'd0);

    // R7: base zero consumes without write
    post(2, 32'h0000_0011);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R7 no write at zero base", {31'd0, mem_req}, 32'd0);
    end

    // R2, R3, R4, R5 table walk, 16-word queue wraps on 17th
    len_code = 8'd0;
    set_base(32'h0000_1000);
    for (int i = 0; i < 17; i++) begin
      logic [65:0] v;
      v = TBL[i % 8];
      post(int'(v[65:64]), v[63:32]);
      serve(i % 3, a, d);
      chk("R3 ring address", a, 32'h0000_1000 + 32'(4 * (i % 16)));
      chk("R4 R5 entry word", d, v[31:0]);
      @(negedge clk);
      chk("R9 irq one cycle", {31'd0, irq}, 32'd0);
    end

    // R2: reload mid-ring
    set_base(32'h0000_2000);
    post(0, 32'd0);
    serve(0, a, d);
    chk("R2 reload addr", a, 32'h0000_2000);
    chk("R5 ack word", d, 32'h8000_8000);

    // R6 priority
    @(negedge clk);
    ack_req = 1'b1; fi_req = 1'b1; fi_chan = 5'd9; gen_req = 1'b1; gen_word = 32'h0000_00AA;
    @(negedge clk);
    chk("R6 ack first", {29'd0, ack_done, fi_done, gen_done}, 32'd4);
    ack_req = 1'b0;
    serve(1, a, d);
    chk("R6 ack word", d, 32'h8000_8000);
    chk("R3 next addr", a, 32'h0000_2004);
    @(negedge clk);
    chk("R6 fi second", {29'd0, ack_done, fi_done, gen_done}, 32'd2);
    fi_req = 1'b0;
    serve(0, a, d);
    chk("R6 fi word", d, 32'h8000_1009);
    @(negedge clk);
    chk("R6 gen third", {29'd0, ack_done, fi_done, gen_done}, 32'd1);
    gen_req = 1'b0;
    serve(2, a, d);
    chk("R6 gen word", d, 32'h8000_00AA);
    chk("R3 addr after priority", a, 32'h0000_200C);

    // R3: 32-word queue
    len_code = 8'd1;
    set_base(32'h0000_3000);
    for (int i = 0; i < 33; i++) begin
      post(2, 32'(i));
      serve(0, a, d);
      chk("R3 len code 1 addr", a, 32'h0000_3000 + 32'(4 * (i % 32)));
    end

    // R7 again after clearing base
    set_base(32'h0000_0000);
    post(1, 32'd2);
    @(negedge clk);
    chk("R7 zero base after clear", {31'd0, mem_req}, 32'd0);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule